// File: doc/BRIEF.md
# Parallel flash read response multiplexer

This block builds the read data of an emulated NOR flash device on a parallel bus. A command sequencer, outside this block, tells it which read mode is in force. There are four modes: plain array read, identifier (autoselect) read, status read and query-table read. On each read strobe the block decodes the address and picks the source. It then presents one registered result on the following clock. The result comes from a synchronous storage RAM, from four identifier configuration words, from the status byte or from a computed query table.

Array reads can be 8, 16 or 32 bits wide. The bytes are packed in either big-endian or little-endian lane order. A status read has a side effect: each one inverts status bit 6, so software that polls the status sees a toggling bit while an operation runs. Identifier reads at the extended-ID offsets fall back to array data when the stored identifier is unset.

The storage RAM has a 32-bit word and a one-cycle read latency. It sits outside the block, and the block addresses it directly from the strobe.

Top module: `flash_rd_mux`

## Requirements
- R1: After synchronous reset, `rd_valid` is 0, `rd_data` is 0, and the status toggle is cleared. The first status read after reset therefore returns bit 6 equal to `status_in[6]`.
- R2: `rd_valid` is 1 in exactly the cycle after each cycle in which `rd_stb` is 1, and `rd_data` carries the result in that cycle. `rd_mode` selects the source: 0 selects array, 1 identifier, 2 status and 3 query.
- R3: The address is reduced modulo `CHIP_BYTES`, a power of two, before any decode. Addresses that differ only above that size return identical data.
- R4: The mode-decode word offset is address bits [7:0] shifted right by log2(`DEV_BYTES`). With the default `DEV_BYTES`=2, byte addresses 2k and 2k+1 decode to the same offset k.
- R5: In array mode, `acc_size` selects the access width: 0 is a byte, 1 a 16-bit halfword and 2 a 32-bit word. Memory byte n of a RAM word is lanes [8n+7:8n], and the lowest byte address is lane 0. A byte read returns the addressed byte. Halfword and word reads put the lowest-addressed byte in the most significant position when `big_endian` is 1, and in the least significant position otherwise. Unused upper bits are 0.
- R6: In identifier mode, offsets 0 and 1 return `id_w0` and `id_w1`, and offset 2 returns 0 (all sectors unprotected). Each value is zero-extended and does not depend on size or byte order.
- R7: In identifier mode, offsets 0x0E and 0x0F return `id_w2` and `id_w3`. The exception is a stored value of 16'hFFFF, which returns array data instead. Every other offset also returns array data.
- R8: A status read returns `status_in` with bit 6 inverted by the toggle state, in bits [7:0], with bits [31:8] set to 0. Each status read inverts the toggle for the next one.
- R9: Reads in modes other than status leave the toggle unchanged.
- R10: A query read returns the table byte for the offset in bits [7:0], with bits [31:8] set to 0. Offset 0x2D holds the sector count minus one, and 0x2F holds the sector size divided by 256. Offsets at or past the table length (0x36) return 0.
- R11: Query offsets 0x10, 0x11 and 0x12 return 0x51, 0x52 and 0x59. Offsets 0x13 and 0x14 return 0x02 and 0x00. Offset 0x27 returns log2(`CHIP_BYTES`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| rd_addr | input | ADDR_W | Byte address of the access |
| rd_mode | input | 2 | Read mode from the sequencer |
| acc_size | input | 2 | Access width code |
| big_endian | input | 1 | Lane order for multi-byte array reads |
| id_w0 | input | 16 | Primary identifier word 0 |
| id_w1 | input | 16 | Primary identifier word 1 |
| id_w2 | input | 16 | Extended identifier word 2 |
| id_w3 | input | 16 | Extended identifier word 3 |
| status_in | input | 8 | Status byte from the sequencer |
| ram_addr | output | CHIP_AW-2 | Storage RAM word address |
| ram_rd | output | 1 | Storage RAM read enable |
| ram_rdata | input | 32 | Storage RAM read word, one cycle after ram_rd |
| rd_data | output | 32 | Read result |
| rd_valid | output | 1 | Read result valid |

## Verification
The stimulus covers every read mode. Each address is chosen so that each expected value can come from only one source. Array reads cover all three widths in both byte orders at unaligned lanes, which separates lane selection from byte ordering. Identifier reads pair a set extended ID with one of 16'hFFFF, and also read at an unassigned offset; this separates the fixed-value path from the array fallback. A run of status reads, with array and query reads between them and a reset in the middle, separates per-read toggling from toggling on any strobe.

// File: rtl/flr_pkg.sv
package flr_pkg;

    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_IDENT  = 2'd1,
        MODE_STATUS = 2'd2,
        MODE_QUERY  = 2'd3
    } rd_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic {
        SRC_ARRAY = 1'b0,
        SRC_FIXED = 1'b1
    } src_e;

    // Context captured on the strobe edge, consumed when RAM data returns
    typedef struct packed {
        src_e        src;
        logic [31:0] fixed;
        logic [1:0]  lane;
        acc_size_e   size;
        logic        be;
    } rsp_ctx_t;

    localparam logic [7:0] QUERY_LEN = 8'h36;
    localparam int         STAT_TGL_BIT = 6;

    // Arrange RAM word bytes into the bus result
    function automatic logic [31:0] pack_lanes(input logic [31:0] w,
                                               input logic [1:0]  lane,
                                               input acc_size_e   sz,
                                               input logic        be);
        logic [7:0] lo;
        logic [7:0] hi;
        logic [31:0] res;
        lo = lane[1] ? w[23:16] : w[7:0];
        hi = lane[1] ? w[31:24] : w[15:8];
        case (sz)
            SZ_BYTE: res = {24'h0, w[{lane, 3'b000} +: 8]};
            SZ_HALF: res = be ? {16'h0, lo, hi} : {16'h0, hi, lo};
            default: res = be ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/flr_addr_decode.sv
module flr_addr_decode #(
    parameter int ADDR_W     = 20,
    parameter int CHIP_BYTES = 4096,
    parameter int DEV_BYTES  = 2
) (
    input  logic [ADDR_W-1:0]              addr,
    output logic [$clog2(CHIP_BYTES)-1:0]  masked,
    output logic [7:0]                     word_off
);
    localparam int CHIP_AW = $clog2(CHIP_BYTES);

    assign masked = addr[CHIP_AW-1:0];

    generate
        if (DEV_BYTES == 4) begin : g_w32
            assign word_off = {2'b00, masked[7:2]};
        end else if (DEV_BYTES == 2) begin : g_w16
            assign word_off = {1'b0, masked[7:1]};
        end else begin : g_w8
            assign word_off = masked[7:0];
        end
    endgenerate
endmodule

// File: rtl/flr_ident_sel.sv
module flr_ident_sel (
    input  logic [7:0]  off,
    input  logic [15:0] id0,
    input  logic [15:0] id1,
    input  logic [15:0] id2,
    input  logic [15:0] id3,
    output logic        hit,
    output logic [31:0] val
);
    logic [15:0] ext_id;

    assign ext_id = off[0] ? id3 : id2;

    always_comb begin
        hit = 1'b0;
        val = 32'h0;
        case (off)
            8'h00: begin hit = 1'b1; val = {16'h0, id0}; end
            8'h01: begin hit = 1'b1; val = {16'h0, id1}; end
            8'h02: begin hit = 1'b1; val = 32'h0; end
            8'h0E, 8'h0F: begin
                hit = (ext_id != 16'hFFFF);
                val = {16'h0, ext_id};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/flr_status_tgl.sv
module flr_status_tgl
    import flr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       flip,
    input  logic [7:0] status_in,
    output logic [7:0] status_out,
    output logic       tgl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tgl <= 1'b0;
        end else if (flip) begin
            tgl <= ~tgl;
        end
    end

    always_comb begin
        status_out = status_in;
        status_out[STAT_TGL_BIT] = status_in[STAT_TGL_BIT] ^ tgl;
    end
endmodule

// File: rtl/flr_query_rom.sv
module flr_query_rom
    import flr_pkg::*;
#(
    parameter int CHIP_BYTES   = 4096,
    parameter int SECTOR_BYTES = 1024
) (
    input  logic [7:0] off,
    output logic [7:0] qbyte
);
    localparam int         NSEC_M1   = CHIP_BYTES / SECTOR_BYTES - 1;
    localparam logic [7:0] SIZE_LOG2 = 8'($clog2(CHIP_BYTES));
    localparam logic [7:0] NSEC_LO   = 8'(NSEC_M1);
    localparam logic [7:0] NSEC_HI   = 8'(NSEC_M1 >> 8);
    localparam logic [7:0] SEC_LO    = 8'(SECTOR_BYTES >> 8);
    localparam logic [7:0] SEC_HI    = 8'(SECTOR_BYTES >> 16);

    always_comb begin
        qbyte = 8'h00;
        if (off < QUERY_LEN) begin
            case (off)
                8'h10: qbyte = 8'h51;
                8'h11: qbyte = 8'h52;
                8'h12: qbyte = 8'h59;
                8'h13: qbyte = 8'h02;
                8'h15: qbyte = 8'h31;
                8'h1B: qbyte = 8'h27;
                8'h1C: qbyte = 8'h36;
                8'h1F: qbyte = 8'h07;
                8'h21: qbyte = 8'h09;
                8'h22: qbyte = 8'h0C;
                8'h23: qbyte = 8'h01;
                8'h25: qbyte = 8'h0A;
                8'h26: qbyte = 8'h0D;
                8'h27: qbyte = SIZE_LOG2;
                8'h28: qbyte = 8'h02;
                8'h2C: qbyte = 8'h01;
                8'h2D: qbyte = NSEC_LO;
                8'h2E: qbyte = NSEC_HI;
                8'h2F: qbyte = SEC_LO;
                8'h30: qbyte = SEC_HI;
                8'h31: qbyte = 8'h50;
                8'h32: qbyte = 8'h52;
                8'h33: qbyte = 8'h49;
                8'h34: qbyte = 8'h31;
                8'h35: qbyte = 8'h30;
                default: qbyte = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/flash_rd_mux.sv
module flash_rd_mux
    import flr_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int CHIP_BYTES   = 4096,
    parameter int SECTOR_BYTES = 1024,
    parameter int DEV_BYTES    = 2,
    localparam int CHIP_AW     = $clog2(CHIP_BYTES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_stb,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [1:0]          rd_mode,
    input  logic [1:0]          acc_size,
    input  logic                big_endian,
    input  logic [15:0]         id_w0,
    input  logic [15:0]         id_w1,
    input  logic [15:0]         id_w2,
    input  logic [15:0]         id_w3,
    input  logic [7:0]          status_in,
    output logic [CHIP_AW-3:0]  ram_addr,
    output logic                ram_rd,
    input  logic [31:0]         ram_rdata,
    output logic [31:0]         rd_data,
    output logic                rd_valid
);
    rd_mode_e           mode;
    logic [CHIP_AW-1:0] masked;
    logic [7:0]         word_off;
    logic               id_hit;
    logic [31:0]        id_val;
    logic [7:0]         stat_byte;
    logic [7:0]         q_byte;
    logic               tgl_q;
    rsp_ctx_t           ctx_d;
    rsp_ctx_t           ctx_q;

    assign mode = rd_mode_e'(rd_mode);

    flr_addr_decode #(
        .ADDR_W(ADDR_W), .CHIP_BYTES(CHIP_BYTES), .DEV_BYTES(DEV_BYTES)
    ) u_dec (
        .addr(rd_addr), .masked(masked), .word_off(word_off)
    );

    flr_ident_sel u_id (
        .off(word_off), .id0(id_w0), .id1(id_w1), .id2(id_w2), .id3(id_w3),
        .hit(id_hit), .val(id_val)
    );

    flr_status_tgl u_st (
        .clk(clk), .rst(rst),
        .flip(rd_stb && (mode == MODE_STATUS)),
        .status_in(status_in), .status_out(stat_byte), .tgl(tgl_q)
    );

    flr_query_rom #(
        .CHIP_BYTES(CHIP_BYTES), .SECTOR_BYTES(SECTOR_BYTES)
    ) u_q (
        .off(word_off), .qbyte(q_byte)
    );

    assign ram_addr = masked[CHIP_AW-1:2];
    assign ram_rd   = rd_stb;

    always_comb begin
        ctx_d.src   = SRC_ARRAY;
        ctx_d.fixed = 32'h0;
        ctx_d.lane  = masked[1:0];
        ctx_d.size  = acc_size_e'(acc_size);
        ctx_d.be    = big_endian;
        case (mode)
            MODE_IDENT: begin
                if (id_hit) begin
                    ctx_d.src   = SRC_FIXED;
                    ctx_d.fixed = id_val;
                end
            end
            MODE_STATUS: begin
                ctx_d.src   = SRC_FIXED;
                ctx_d.fixed = {24'h0, stat_byte};
            end
            MODE_QUERY: begin
                ctx_d.src   = SRC_FIXED;
                ctx_d.fixed = {24'h0, q_byte};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            ctx_q    <= '0;
        end else begin
            rd_valid <= rd_stb;
            if (rd_stb) begin
                ctx_q <= ctx_d;
            end
        end
    end

    always_comb begin
        if (!rd_valid) begin
            rd_data = 32'h0;
        end else if (ctx_q.src == SRC_ARRAY) begin
            rd_data = pack_lanes(ram_rdata, ctx_q.lane, ctx_q.size, ctx_q.be);
        end else begin
            rd_data = ctx_q.fixed;
        end
    end
endmodule

// File: rtl/flash_rd_mux_chk.sv
module flash_rd_mux_chk (
    input logic        clk,
    input logic        rst,
    input logic        rd_stb,
    input logic [1:0]  rd_mode,
    input logic        rd_valid,
    input logic [31:0] rd_data,
    input logic        tgl
);
    AST_VALID_FOLLOWS_STB: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> rd_valid); // R2

    AST_VALID_NEEDS_STB: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_stb)); // R2

    AST_STATUS_FLIPS_TGL: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && rd_mode == 2'd2) |=> (tgl != $past(tgl))); // R8

    AST_OTHER_KEEPS_TGL: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && rd_mode != 2'd2) |=> $stable(tgl)); // R9

    AST_QUERY_NARROW: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(rd_mode) == 2'd3) |-> (rd_data[31:8] == 24'h0)); // R10

    AST_STATUS_NARROW: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(rd_mode) == 2'd2) |-> (rd_data[31:8] == 24'h0)); // R8
endmodule

bind flash_rd_mux flash_rd_mux_chk u_chk (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .rd_mode(rd_mode),
    .rd_valid(rd_valid), .rd_data(rd_data), .tgl(tgl_q)
);

// File: tb/sim_flash_rd_mux.sv
`timescale 1ns/1ps
module sim_flash_rd_mux;
    localparam int ADDR_W = 20;
    localparam int CHIP_AW = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rd_stb = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [1:0]        rd_mode = 2'd0;
    logic [1:0]        acc_size = 2'd0;
    logic              big_endian = 1'b0;
    logic [15:0]       id_w0 = 16'h0001;
    logic [15:0]       id_w1 = 16'h227E;
    logic [15:0]       id_w2 = 16'h2210;
    logic [15:0]       id_w3 = 16'hFFFF;
    logic [7:0]        status_in = 8'h80;
    logic [CHIP_AW-3:0] ram_addr;
    logic              ram_rd;
    logic [31:0]       ram_rdata = '0;
    logic [31:0]       rd_data;
    logic              rd_valid;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    flash_rd_mux u0 (
        .clk(clk), .rst(rst), .rd_stb(rd_stb), .rd_addr(rd_addr),
        .rd_mode(rd_mode), .acc_size(acc_size), .big_endian(big_endian),
        .id_w0(id_w0), .id_w1(id_w1), .id_w2(id_w2), .id_w3(id_w3),
        .status_in(status_in), .ram_addr(ram_addr), .ram_rd(ram_rd),
        .ram_rdata(ram_rdata), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // Content of the storage, as a function of the in-chip byte address
    function automatic logic [7:0] bb(input logic [11:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h3C;
    endfunction

    always @(posedge clk) begin
        if (ram_rd)
            ram_rdata <= {bb({ram_addr, 2'd3}), bb({ram_addr, 2'd2}),
                          bb({ram_addr, 2'd1}), bb({ram_addr, 2'd0})};
    end

    function automatic logic [31:0] exp_arr(input logic [11:0] a,
                                            input logic [1:0] s, input logic b);
        logic [11:0] h;
        logic [11:0] w;
        h = {a[11:1], 1'b0};
        w = {a[11:2], 2'b00};
        case (s)
            2'd0: return {24'h0, bb(a)};
            2'd1: return b ? {16'h0, bb(h), bb(h + 12'd1)}
                           : {16'h0, bb(h + 12'd1), bb(h)};
            default: return b ? {bb(w), bb(w + 12'd1), bb(w + 12'd2), bb(w + 12'd3)}
                              : {bb(w + 12'd3), bb(w + 12'd2), bb(w + 12'd1), bb(w)};
        endcase
    endfunction

    typedef struct packed {
        logic [19:0] a;
        logic [1:0]  m;
        logic [1:0]  s;
        logic        be;
        logic        arr;
        logic [31:0] e;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{20'h00123, 2'd0, 2'd0, 1'b0, 1'b1, 32'h0, 8'd5},      // R5 byte
        '{20'h00246, 2'd0, 2'd1, 1'b0, 1'b1, 32'h0, 8'd5},      // R5 half LE
        '{20'h00246, 2'd0, 2'd1, 1'b1, 1'b1, 32'h0, 8'd5},      // R5 half BE
        '{20'h003F8, 2'd0, 2'd2, 1'b0, 1'b1, 32'h0, 8'd5},      // R5 word LE
        '{20'h003F8, 2'd0, 2'd2, 1'b1, 1'b1, 32'h0, 8'd5},      // R5 word BE
        '{20'h00000, 2'd1, 2'd1, 1'b0, 1'b0, 32'h0001, 8'd6},   // R6 id0
        '{20'h00002, 2'd1, 2'd1, 1'b1, 1'b0, 32'h227E, 8'd6},   // R6 id1, BE
        '{20'h00004, 2'd1, 2'd1, 1'b0, 1'b0, 32'h0, 8'd6},      // R6 protect
        '{20'h0001C, 2'd1, 2'd1, 1'b0, 1'b0, 32'h2210, 8'd7},   // R7 id2
        '{20'h0001E, 2'd1, 2'd1, 1'b0, 1'b1, 32'h0, 8'd7},      // R7 id3 unset
        '{20'h00008, 2'd1, 2'd1, 1'b1, 1'b1, 32'h0, 8'd7},      // R7 other off
        '{20'h00020, 2'd3, 2'd0, 1'b0, 1'b0, 32'h51, 8'd11},    // R11 Q
        '{20'h00022, 2'd3, 2'd0, 1'b0, 1'b0, 32'h52, 8'd11},    // R11 R
        '{20'h00024, 2'd3, 2'd0, 1'b0, 1'b0, 32'h59, 8'd11},    // R11 Y
        '{20'h00026, 2'd3, 2'd0, 1'b0, 1'b0, 32'h02, 8'd11},    // R11 cmd set lo
        '{20'h00028, 2'd3, 2'd0, 1'b0, 1'b0, 32'h00, 8'd11},    // R11 cmd set hi
        '{20'h0004E, 2'd3, 2'd0, 1'b0, 1'b0, 32'h0C, 8'd11},    // R11 size
        '{20'h0005A, 2'd3, 2'd0, 1'b0, 1'b0, 32'h03, 8'd10},    // R10 sectors-1
        '{20'h0005E, 2'd3, 2'd0, 1'b0, 1'b0, 32'h04, 8'd10},    // R10 sector/256
        '{20'h000A0, 2'd3, 2'd0, 1'b0, 1'b0, 32'h00, 8'd10},    // R10 past end
        '{20'hA5123, 2'd0, 2'd0, 1'b0, 1'b1, 32'h0, 8'd3},      // R3 alias array
        '{20'hF0002, 2'd1, 2'd1, 1'b0, 1'b0, 32'h227E, 8'd3},   // R3 alias ident
        '{20'h00021, 2'd3, 2'd0, 1'b0, 1'b0, 32'h51, 8'd4},     // R4 odd byte
        '{20'h00003, 2'd1, 2'd1, 1'b0, 1'b0, 32'h227E, 8'd4}    // R4 odd byte
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [19:0] a, input logic [1:0] m,
                           input logic [1:0] s, input logic b,
                           output logic [31:0] got, output logic vld);
        @(negedge clk);
        rd_addr = a; rd_mode = m; acc_size = s; big_endian = b; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        got = rd_data;
        vld = rd_valid;
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] got;
        logic        vld;
        logic [31:0] exp;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 valid after reset", {31'h0, rd_valid}, 32'h0);
        chk("R1 data after reset", rd_data, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            do_read(VEC[i].a, VEC[i].m, VEC[i].s, VEC[i].be, got, vld);
            exp = VEC[i].arr ? exp_arr(VEC[i].a[11:0], VEC[i].s, VEC[i].be) : VEC[i].e;
            chk($sformatf("R%0d vector %0d", VEC[i].req, i), got, exp);
            chk("R2 valid with data", {31'h0, vld}, 32'h1);
        end

        // R2 valid lasts a single cycle
        @(negedge clk);
        chk("R2 valid drops", {31'h0, rd_valid}, 32'h0);

        // R8 toggling status reads
        do_read(20'h0, 2'd2, 2'd0, 1'b0, got, vld);
        chk("R8 status first", got, 32'h80);
        do_read(20'h0, 2'd2, 2'd0, 1'b0, got, vld);
        chk("R8 status second", got, 32'hC0);
        status_in = 8'h45;
        do_read(20'h0, 2'd2, 2'd2, 1'b1, got, vld);
        chk("R8 status third", got, 32'h45);
        // R9 other reads in between keep the toggle
        do_read(20'h00123, 2'd0, 2'd0, 1'b0, got, vld);
        do_read(20'h00020, 2'd3, 2'd0, 1'b0, got, vld);
        do_read(20'h00000, 2'd1, 2'd1, 1'b0, got, vld);
        do_read(20'h0, 2'd2, 2'd0, 1'b0, got, vld);
        chk("R9 status after other reads", got, 32'h05);
        // toggle now 0; one more read sets it, then reset must clear it
        do_read(20'h0, 2'd2, 2'd0, 1'b0, got, vld);
        chk("R8 status fifth", got, 32'h45);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 valid in reset", {31'h0, rd_valid}, 32'h0);
        rst = 1'b0;
        do_read(20'h0, 2'd2, 2'd0, 1'b0, got, vld);
        chk("R1 toggle cleared by reset", got, 32'h45);

        // R7 extended ID set back to a real value
        id_w3 = 16'h0101;
        do_read(20'h0001E, 2'd1, 2'd1, 1'b0, got, vld);
        chk("R7 id3 set", got, 32'h0101);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule